// File: doc/BRIEF.md
# Resolver Converter Parallel Read Controller

This block is a synchronous host-side sequencer that collects one angle word and one speed word from an external resolver-to-digital converter over a 12-bit parallel bus. A single-cycle start request in the idle state begins a transaction. The block first drives an active-low freeze strobe, which makes the converter latch its current results. It then waits out the converter's settling time. Next it lowers chip select and the read strobe with the register-select line high to read the angle word. After a recovery gap with the read strobe high, it performs a second read with the select line low to fetch the speed word. Once both words are captured, it raises a one-cycle done pulse and presents both words on its outputs.

Every minimum time is given as a parameter in system-clock cycles. The integrator rounds each analog limit up to whole cycles, and the block widens some windows further where two limits overlap. The bus is sampled in the last cycle of each read window, after the converter's enable delay has elapsed. All strobes come straight from flip-flops. Start requests that arrive while a transaction runs are dropped.

Top module: `rdc_par_reader`

## Requirements
- R1: While reset is asserted and afterwards until a start request, the outputs are at rest: freeze_no=1, cs_no=1, rd_no=1, sel_pos_o=1, done_o=0, pos_o=0, vel_o=0.
- R2: A start_i sampled high in the idle state drives freeze_no low for exactly S=max(FRZ_LOW_CYC,1) cycles, starting in the cycle after that clock edge.
- R3: After freeze_no returns high, cs_no and rd_no stay high for W=max(FRZ_TO_RD_CYC,SEL_SETUP_CYC,1) cycles. Then cs_no and rd_no fall together with sel_pos_o=1, which selects the angle register.
- R4: Each read window (rd_no low) lasts L=max(RD_LOW_CYC,SEL_HOLD_CYC,EN_DLY_CYC+1) cycles. The bus value present in the last cycle of that window is the word that is stored.
- R5: Between the two reads, rd_no is high for G=max(RD_HIGH_CYC,SEL_SETUP_CYC,1) cycles while cs_no stays low. sel_pos_o goes low at the first gap cycle, so the second read has sel_pos_o=0, which selects the speed register.
- R6: sel_pos_o holds its value in the cycle in which rd_no falls and in every cycle of a read window.
- R7: done_o is high for exactly one cycle, the cycle right after the second read window, with cs_no and rd_no high. pos_o and vel_o hold the two captured words from that cycle until the next done pulse.
- R8: start_i is ignored in every cycle except the idle state, including the done cycle. A transaction is never restarted or lengthened.
- R9: cs_no is high outside a transaction. rd_no is low only while cs_no is low. freeze_no is never low while cs_no is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Transaction request, sampled in idle only |
| bus_i | input | DW | Data bus from the converter |
| freeze_no | output | 1 | Result freeze strobe, active low |
| cs_no | output | 1 | Chip select, active low |
| rd_no | output | 1 | Read strobe, active low |
| sel_pos_o | output | 1 | Register select: 1 angle, 0 speed |
| pos_o | output | DW | Captured angle word |
| vel_o | output | DW | Captured speed word |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions check the strobe relations on every cycle:
- read only under chip select;
- no freeze during a transaction;
- select stable at each read edge and through each window;
- angle select on the first read and speed select on the second;
- a single-cycle done pulse with both strobes idle.

The bench's scenarios show the exact length of each phase and the cycle in which the bus is captured. The bench's converter model returns garbage until the enable delay has passed, and it freezes its live values on the freeze strobe. The scenarios also show that start requests in every busy cycle are dropped.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FRZ, ST_WAIT, ST_RD1, ST_GAP, ST_RD2, ST_DONE
  } rdc_st_e;

  typedef struct packed {
    logic frz_n;
    logic cs_n;
    logic rd_n;
    logic sel_pos;
    logic done;
  } rdc_pins_t;

  localparam rdc_pins_t PINS_IDLE = '{frz_n: 1'b1, cs_n: 1'b1, rd_n: 1'b1,
                                      sel_pos: 1'b1, done: 1'b0};

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/rdc_timer.sv
module rdc_timer #(
  parameter int unsigned TW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/rdc_seq.sv
module rdc_seq
  import rdc_pkg::*;
#(
  parameter int unsigned   TW      = 4,
  parameter logic [TW-1:0] FRZ_LD  = '0,
  parameter logic [TW-1:0] WAIT_LD = '0,
  parameter logic [TW-1:0] RD_LD   = '0,
  parameter logic [TW-1:0] GAP_LD  = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          tmr_zero_i,
  output rdc_st_e       st_o,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  output rdc_pins_t     pins_o
);
  rdc_st_e   st_q, st_d;
  rdc_pins_t pins_q;

  // pin image of a state; registered from the next state so pins track st_q
  function automatic rdc_pins_t decode(rdc_st_e s);
    rdc_pins_t p;
    p = PINS_IDLE;
    case (s)
      ST_FRZ:  p.frz_n = 1'b0;
      ST_RD1:  begin p.cs_n = 1'b0; p.rd_n = 1'b0; end
      ST_GAP:  begin p.cs_n = 1'b0; p.sel_pos = 1'b0; end
      ST_RD2:  begin p.cs_n = 1'b0; p.rd_n = 1'b0; p.sel_pos = 1'b0; end
      ST_DONE: p.done = 1'b1;
      default: ;
    endcase
    return p;
  endfunction

  always_comb begin
    st_d       = st_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    case (st_q)
      ST_IDLE: if (start_i) begin
        st_d = ST_FRZ; tmr_load_o = 1'b1; tmr_val_o = FRZ_LD;
      end
      ST_FRZ: if (tmr_zero_i) begin
        st_d = ST_WAIT; tmr_load_o = 1'b1; tmr_val_o = WAIT_LD;
      end
      ST_WAIT: if (tmr_zero_i) begin
        st_d = ST_RD1; tmr_load_o = 1'b1; tmr_val_o = RD_LD;
      end
      ST_RD1: if (tmr_zero_i) begin
        st_d = ST_GAP; tmr_load_o = 1'b1; tmr_val_o = GAP_LD;
      end
      ST_GAP: if (tmr_zero_i) begin
        st_d = ST_RD2; tmr_load_o = 1'b1; tmr_val_o = RD_LD;
      end
      ST_RD2:  if (tmr_zero_i) st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      pins_q <= PINS_IDLE;
    end else begin
      st_q   <= st_d;
      pins_q <= decode(st_d);
    end
  end

  assign st_o   = st_q;
  assign pins_o = pins_q;
endmodule

// File: rtl/rdc_capture.sv
module rdc_capture #(
  parameter int unsigned DW    = 12,
  parameter int unsigned NSLOT = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [DW-1:0]             bus_i,
  input  logic [NSLOT-1:0]          cap_i,
  output logic [NSLOT-1:0][DW-1:0]  word_o
);
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic [DW-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       word_q <= '0;
      else if (cap_i[g]) word_q <= bus_i;
    end
    assign word_o[g] = word_q;
  end
endmodule

// File: rtl/rdc_par_reader.sv
module rdc_par_reader
  import rdc_pkg::*;
#(
  parameter int unsigned DW            = 12,
  parameter int unsigned FRZ_LOW_CYC   = 18,  // freeze pulse width
  parameter int unsigned FRZ_TO_RD_CYC = 50,  // freeze release to first read
  parameter int unsigned SEL_SETUP_CYC = 1,
  parameter int unsigned SEL_HOLD_CYC  = 1,
  parameter int unsigned RD_LOW_CYC    = 1,
  parameter int unsigned EN_DLY_CYC    = 1,   // bus valid after this many low cycles
  parameter int unsigned RD_HIGH_CYC   = 2    // recovery, also covers bus release
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] bus_i,
  output logic          freeze_no,
  output logic          cs_no,
  output logic          rd_no,
  output logic          sel_pos_o,
  output logic [DW-1:0] pos_o,
  output logic [DW-1:0] vel_o,
  output logic          done_o
);
  localparam int unsigned FRZ_CYC  = max3(FRZ_LOW_CYC, 1, 1);
  localparam int unsigned WAIT_CYC = max3(FRZ_TO_RD_CYC, SEL_SETUP_CYC, 1);
  localparam int unsigned RD_CYC   = max3(RD_LOW_CYC, SEL_HOLD_CYC, EN_DLY_CYC + 1);
  localparam int unsigned GAP_CYC  = max3(RD_HIGH_CYC, SEL_SETUP_CYC, 1);
  localparam int unsigned MAX_CYC  = max3(max3(FRZ_CYC, WAIT_CYC, RD_CYC), GAP_CYC, 1);
  localparam int unsigned TW       = ($clog2(MAX_CYC) < 1) ? 1 : $clog2(MAX_CYC);
  localparam logic [TW-1:0] FRZ_LD  = TW'(FRZ_CYC - 1);
  localparam logic [TW-1:0] WAIT_LD = TW'(WAIT_CYC - 1);
  localparam logic [TW-1:0] RD_LD   = TW'(RD_CYC - 1);
  localparam logic [TW-1:0] GAP_LD  = TW'(GAP_CYC - 1);

  rdc_st_e              st;
  logic                 tmr_load, tmr_zero;
  logic [TW-1:0]        tmr_val;
  rdc_pins_t            pins;
  logic [1:0]           cap;
  logic [1:0][DW-1:0]   words;

  rdc_timer #(.TW(TW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  rdc_seq #(
    .TW(TW), .FRZ_LD(FRZ_LD), .WAIT_LD(WAIT_LD), .RD_LD(RD_LD), .GAP_LD(GAP_LD)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .tmr_zero_i (tmr_zero),
    .st_o       (st),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .pins_o     (pins)
  );

  // sample on the last cycle of each read window
  assign cap[0] = (st == ST_RD1) && tmr_zero;
  assign cap[1] = (st == ST_RD2) && tmr_zero;

  rdc_capture #(.DW(DW), .NSLOT(2)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bus_i  (bus_i),
    .cap_i  (cap),
    .word_o (words)
  );

  assign freeze_no = pins.frz_n;
  assign cs_no     = pins.cs_n;
  assign rd_no     = pins.rd_n;
  assign sel_pos_o = pins.sel_pos;
  assign done_o    = pins.done;
  assign pos_o     = words[0];
  assign vel_o     = words[1];
endmodule

// File: rtl/rdc_par_reader_chk.sv
module rdc_par_reader_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic freeze_no,
  input logic cs_no,
  input logic rd_no,
  input logic sel_pos_o,
  input logic done_o
);
  // R9
  rd_needs_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !cs_no);
  // R9
  no_freeze_in_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !freeze_no |-> cs_no);
  // R6
  sel_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_no) |-> $stable(sel_pos_o));
  // R6
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no && !$past(rd_no)) |-> $stable(sel_pos_o));
  // R3
  first_read_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> (sel_pos_o && !rd_no));
  // R5
  second_read_vel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rd_no) && !$fell(cs_no)) |-> !sel_pos_o);
  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (rd_no && cs_no && freeze_no));
endmodule

bind rdc_par_reader rdc_par_reader_chk u_chk (.*);

// File: tb/rdc_par_reader_tb_top.sv
module rdc_par_reader_tb_top;
  localparam int DW = 12;
  localparam int P_FRZ = 3, P_F2R = 4, P_SU = 5, P_HD = 2, P_RDL = 2, P_EN = 3, P_RDH = 2;

  function automatic int mx(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  localparam int S   = mx(P_FRZ, 1, 1);
  localparam int W   = mx(P_F2R, P_SU, 1);
  localparam int L   = mx(P_RDL, P_HD, P_EN + 1);
  localparam int G   = mx(P_RDH, P_SU, 1);
  localparam int R1S = S + W + 1;
  localparam int R1E = S + W + L;
  localparam int R2S = R1E + G + 1;
  localparam int R2E = R1E + G + L;
  localparam int DN  = R2E + 1;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [DW-1:0] bus_i, pos_o, vel_o;
  logic freeze_no, cs_no, rd_no, sel_pos_o, done_o;

  int checks = 0, errors = 0;
  logic [DW-1:0] live_pos = '0, live_vel = '0, frz_pos = '0, frz_vel = '0;
  logic [DW-1:0] prev_pos = '0, prev_vel = '0;
  int lowcnt = 0;

  always #10 clk_i = ~clk_i;

  rdc_par_reader #(
    .DW(DW), .FRZ_LOW_CYC(P_FRZ), .FRZ_TO_RD_CYC(P_F2R), .SEL_SETUP_CYC(P_SU),
    .SEL_HOLD_CYC(P_HD), .RD_LOW_CYC(P_RDL), .EN_DLY_CYC(P_EN), .RD_HIGH_CYC(P_RDH)
  ) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .bus_i(bus_i),
    .freeze_no(freeze_no), .cs_no(cs_no), .rd_no(rd_no), .sel_pos_o(sel_pos_o),
    .pos_o(pos_o), .vel_o(vel_o), .done_o(done_o)
  );

  // converter model: freezes on strobe, data valid after P_EN low cycles
  always @(posedge clk_i) begin
    if (!freeze_no) begin frz_pos <= live_pos; frz_vel <= live_vel; end
    if (!rd_no && !cs_no) lowcnt <= lowcnt + 1;
    else                  lowcnt <= 0;
  end
  always_comb begin
    if (!rd_no && !cs_no && lowcnt >= P_EN) bus_i = sel_pos_o ? frz_pos : frz_vel;
    else                                    bus_i = ~(sel_pos_o ? frz_pos : frz_vel);
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle pin image {frz_n, cs_n, rd_n, sel, done} for cycle k of a transaction
  function automatic logic [4:0] exp_pins(int k);
    logic f, c, r, s, d;
    f = !(k >= 1 && k <= S);
    c = !(k >= R1S && k <= R2E);
    r = !((k >= R1S && k <= R1E) || (k >= R2S && k <= R2E));
    s = !(k > R1E && k <= R2E);
    d = (k == DN);
    return {f, c, r, s, d};
  endfunction

  task automatic run(input logic [DW-1:0] pv, input logic [DW-1:0] vv, input int ek);
    @(negedge clk_i);
    live_pos = pv; live_vel = vv; start_i = 1'b1;
    for (int k = 1; k <= DN + 3; k++) begin
      @(negedge clk_i);
      start_i = (k == ek);
      if (k == S + 1) begin live_pos = ~pv; live_vel = ~vv; end
      // R2 R3 R4 R5 R7 R8 R9 phase trace
      chk({freeze_no, cs_no, rd_no, sel_pos_o, done_o} == exp_pins(k),
          (ek != 0) ? "R8 trace with busy start" : "R2/R3/R5 trace",
          {27'd0, freeze_no, cs_no, rd_no, sel_pos_o, done_o}, {27'd0, exp_pins(k)});
      if (k == R1E) chk(pos_o == prev_pos && vel_o == prev_vel, "R7 hold mid-run",
                        {pos_o, vel_o}, {prev_pos, prev_vel});
      if (k == DN) chk(pos_o == pv && vel_o == vv, "R4 captured words",
                       {pos_o, vel_o}, {pv, vv});
      if (k == DN + 3) chk(pos_o == pv && vel_o == vv, "R7 words held",
                           {pos_o, vel_o}, {pv, vv});
    end
    start_i = 1'b0;
    prev_pos = pv; prev_vel = vv;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk({freeze_no, cs_no, rd_no, sel_pos_o, done_o} == 5'b11110, "R1 pins in reset",
        {27'd0, freeze_no, cs_no, rd_no, sel_pos_o, done_o}, 32'h1e);
    chk(pos_o == '0 && vel_o == '0, "R1 words in reset", {pos_o, vel_o}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk({freeze_no, cs_no, rd_no, sel_pos_o, done_o} == 5'b11110, "R1 idle after reset",
        {27'd0, freeze_no, cs_no, rd_no, sel_pos_o, done_o}, 32'h1e);
    run(12'h000, 12'hFFF, 0);
    run(12'hFFF, 12'h000, 0);
    run(12'hAAA, 12'h555, 0);
    run(12'h555, 12'hAAA, 0);
    for (int i = 0; i < 16; i++)
      run(DW'((i * 32'h249 + 7) & 32'hFFF), DW'((32'hFFF - i * 32'h111) & 32'hFFF), 0);
    // R8: start requests in every busy cycle, done cycle included
    for (int ek = 1; ek <= DN; ek++)
      run(DW'((ek * 32'h3C5) & 32'hFFF), DW'((ek * 32'h1A7 + 32'h80) & 32'hFFF), ek);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule